// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog timer with a small synchronous register port. Once enabled, it counts down in two stages that run one after the other. When the first stage runs out, the block can raise a level interrupt. If software still has not restarted the count when the second stage runs out, the block drives a fixed-length reset pulse and sets a sticky timeout flag. That flag survives the system reset the watchdog causes, and only a power-on reset clears it. Software can therefore tell, after boot, that the last reset came from the watchdog.

The preload, restart and flag-clear registers are guarded. A write to any of them takes effect only right after a two-write magic sequence to the restart register, and each such sequence opens the guard for a single write. A control register enables counting and selects the mode. It also holds a lock bit. Once the lock is set, the enable cannot be cleared and the configuration is frozen, until the next reset.

A prescaler divides the bus clock into ticks. At the slow rate there is one tick per 2^15 clocks, so a preload of (seconds << 9) in each stage gives roughly 1024 ticks per second across the two stages. The fast rate gives one tick per 2^5 clocks. In free-running mode the block only produces periodic first-stage interrupts and never times out.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset, both preloads read 15360 (30 << 9). The interrupt status, restart/flag, configuration and control registers all read 0, and `irq_o` and `wdt_rst_o` are low.
- R2: Offsets are 0x00 (stage-1 preload), 0x04 (stage-2 preload), 0x08 (interrupt status), 0x0C (restart/flag), 0x10 (configuration) and 0x14 (control). Writing 16'h0080 and then 16'h0086 (byte lane 0 enabled) to 0x0C opens the guard. The next write to 0x00, 0x04 or 0x0C is accepted, and the guard then closes, so a second such write is ignored. Writes to 0x08, 0x10 and 0x14 neither need nor close the guard.
- R3: A guarded write without a complete magic pair is ignored. Any bus write other than 16'h0086 between 16'h0080 and 16'h0086 cancels the sequence.
- R4: Preload writes honour the byte enables. Each preload holds 20 bits.
- R5: A stage loaded with value P lasts max(P,1) ticks. When stage 1 runs out, status bit 0 of 0x08 and `irq_o` go high. They do not go high when configuration bits 1:0 are 11.
- R6: Stage 2 starts when stage 1 runs out. When stage 2 runs out, flag bit 9 of 0x0C is set and counting stops. If configuration bit 5 is 0, `wdt_rst_o` is also high for exactly 8 cycles; if bit 5 is 1, `wdt_rst_o` stays low.
- R7: An accepted write to 0x0C with bit 8 set restarts stage 1 from its preload and clears the prescaler. With bit 9 set, the same write clears the flag.
- R8: Control bit 0 is a sticky lock. While the lock is set, enable (bit 1) cannot be cleared, mode (bit 2) and the configuration register are frozen, and a read of 0x14 shows the enable still set.
- R9: The timeout flag survives a `sys_rst_n` reset, which returns every other register to its reset value. The flag is cleared only by `por_n`.
- R10: With control bit 2 set (free-running), stage 1 reloads itself on every expiry and raises the interrupt each time. No timeout or reset pulse ever occurs.
- R11: Writing 1 to bit 0 of 0x08 clears the interrupt status and `irq_o`. Writing 0 leaves them unchanged.
- R12: With enable clear, no ticks are counted and no interrupt or timeout occurs.
- R13: Configuration bit 2 selects the tick period: 0 gives 2^15 clocks, 1 gives 2^5 clocks. The period is counted from the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, keeps the timeout flag |
| bus_addr | input | ADDR_W | Local byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Stage-1 interrupt level |
| wdt_rst_o | output | 1 | Registered reset pulse on stage-2 expiry |

## Verification
Read data is combinational, so a register written at one clock edge reads back any time after that edge. The bench samples every result on the falling edge. For a restart at edge E with the fast rate, the interrupt is due at edge E+32·max(P1,1), and the bench samples one cycle before that edge (expecting low) and right after it (expecting high). The reset pulse and flag are due 32·max(P2,1) cycles later. The pulse is checked high on its eighth cycle and low on the ninth. The slow rate is checked the same way with 32768 clocks per tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] OFF_PRE1 = 8'h00;
  localparam logic [7:0] OFF_PRE2 = 8'h04;
  localparam logic [7:0] OFF_ISR  = 8'h08;
  localparam logic [7:0] OFF_RLD  = 8'h0C;
  localparam logic [7:0] OFF_CFG  = 8'h10;
  localparam logic [7:0] OFF_CTL  = 8'h14;

  localparam logic [15:0] KEY_FIRST  = 16'h0080;
  localparam logic [15:0] KEY_SECOND = 16'h0086;

  localparam int RLD_RESTART = 8;
  localparam int RLD_TMO     = 9;
  localparam int CTL_LOCK    = 0;
  localparam int CTL_EN      = 1;
  localparam int CTL_MODE    = 2;
  localparam int CFG_NOBOOT  = 5;
  localparam int CFG_FAST    = 2;

  localparam logic [1:0] ITYPE_NONE = 2'b11;

  typedef enum logic [1:0] {
    GUARD_SHUT  = 2'd0,
    GUARD_HALF  = 2'd1,
    GUARD_OPEN  = 2'd2
  } guard_e;

  typedef struct packed {
    logic       noboot;
    logic       fast;
    logic [1:0] itype;
  } cfg_t;

  typedef struct packed {
    logic freerun;
    logic en;
    logic lock;
  } ctl_t;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              be0,
  input  logic [15:0]       wdata,
  output logic              accept
);
  localparam logic [ADDR_W-1:0] A_PRE1 = OFF_PRE1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_PRE2 = OFF_PRE2[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_RLD  = OFF_RLD[ADDR_W-1:0];

  guard_e st_q, st_d;
  logic   key1, key2, guarded;

  always_comb begin
    key1    = wr && (addr == A_RLD) && be0 && (wdata == KEY_FIRST);
    key2    = wr && (addr == A_RLD) && be0 && (wdata == KEY_SECOND);
    guarded = wr && ((addr == A_PRE1) || (addr == A_PRE2) || (addr == A_RLD));
    accept  = 1'b0;
    st_d    = st_q;
    unique case (st_q)
      GUARD_SHUT: if (key1) st_d = GUARD_HALF;
      GUARD_HALF: if (wr) begin
        if (key2)      st_d = GUARD_OPEN;
        else if (key1) st_d = GUARD_HALF;
        else           st_d = GUARD_SHUT;
      end
      GUARD_OPEN: if (guarded) begin
        accept = 1'b1;
        st_d   = key1 ? GUARD_HALF : GUARD_SHUT;
      end
      default: st_d = GUARD_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GUARD_SHUT;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic fast,
  output logic tick
);
  localparam int PW = SLOW_SH;
  localparam logic [PW-1:0] SLOW_MASK = {PW{1'b1}};
  localparam logic [PW-1:0] FAST_MASK = {{(PW-FAST_SH){1'b0}}, {FAST_SH{1'b1}}};

  logic [PW-1:0] psc_q, psc_d, mask;
  logic          psc_ld;

  always_comb begin
    mask   = fast ? FAST_MASK : SLOW_MASK;
    tick   = run && !clear && ((psc_q & mask) == mask);
    psc_d  = (clear || !run) ? '0 : psc_q + 1'b1;
    psc_ld = run || clear || (psc_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc_q <= '0;
    else if (psc_ld) psc_q <= psc_d;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic          freerun,
  input  logic [PW-1:0] pre1,
  input  logic [PW-1:0] pre2,
  output logic          stage1_evt,
  output logic          timeout_evt,
  output logic          expired
);
  logic          second_q, second_d;
  logic          done_q, done_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          ld;

  always_comb begin
    second_d    = second_q;
    done_d      = done_q;
    cnt_d       = cnt_q;
    ld          = 1'b0;
    stage1_evt  = 1'b0;
    timeout_evt = 1'b0;
    if (restart) begin
      ld       = 1'b1;
      second_d = 1'b0;
      done_d   = 1'b0;
      cnt_d    = pre1;
    end else if (tick && !done_q) begin
      ld = 1'b1;
      if (cnt_q <= PW'(1)) begin
        if (!second_q) begin
          stage1_evt = 1'b1;
          if (freerun) cnt_d = pre1;
          else begin
            second_d = 1'b1;
            cnt_d    = pre2;
          end
        end else begin
          timeout_evt = 1'b1;
          done_d      = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (ld) begin
      second_q <= second_d;
      done_q   <= done_d;
      cnt_q    <= cnt_d;
    end
  end

  assign expired = done_q;
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5,
  parameter int RST_CYC = 8,
  parameter logic [PRE_W-1:0] PRE_INIT = PRE_W'(15360)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);
  localparam logic [ADDR_W-1:0] A_PRE1 = OFF_PRE1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_PRE2 = OFF_PRE2[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_ISR  = OFF_ISR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_RLD  = OFF_RLD[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CFG  = OFF_CFG[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTL  = OFF_CTL[ADDR_W-1:0];

  function automatic logic [PRE_W-1:0] lane_merge(logic [PRE_W-1:0] old,
                                                  logic [31:0] d, logic [3:0] be);
    logic [31:0] w;
    w = 32'(old);
    for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
    return w[PRE_W-1:0];
  endfunction

  logic core_arst_n, core_rst_n, por_rst_n;
  assign core_arst_n = por_n & sys_rst_n;

  wdt_rst_sync u_core_sync (.clk(clk), .arst_n(core_arst_n), .srst_n(core_rst_n));
  wdt_rst_sync u_por_sync  (.clk(clk), .arst_n(por_n),       .srst_n(por_rst_n));

  logic prot_wr;
  wdt_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst_n(core_rst_n), .wr(bus_wr), .addr(bus_addr),
    .be0(bus_be[0]), .wdata(bus_wdata[15:0]), .accept(prot_wr)
  );

  logic [PRE_W-1:0] pre1_q, pre1_d, pre2_q, pre2_d;
  logic             pre1_ld, pre2_ld;
  ctl_t             ctl_q, ctl_d;
  cfg_t             cfg_q, cfg_d;
  logic             ctl_wr, cfg_wr;
  logic             isr_q, isr_d, isr_set, isr_clr;
  logic             tmo_q, tmo_d, tmo_clr;
  logic             pulse_q, pulse_d;
  logic [RC_W-1:0]  pcnt_q, pcnt_d;
  logic             rld_wr, restart, en_rise;
  logic             tick, run, stage1_evt, timeout_evt, expired;

  always_comb begin
    pre1_ld = prot_wr && (bus_addr == A_PRE1);
    pre2_ld = prot_wr && (bus_addr == A_PRE2);
    pre1_d  = lane_merge(pre1_q, bus_wdata, bus_be);
    pre2_d  = lane_merge(pre2_q, bus_wdata, bus_be);
    rld_wr  = prot_wr && (bus_addr == A_RLD) && bus_be[1];
    tmo_clr = rld_wr && bus_wdata[RLD_TMO];

    ctl_wr = bus_wr && (bus_addr == A_CTL) && bus_be[0];
    ctl_d  = ctl_q;
    if (ctl_wr) begin
      ctl_d.lock = ctl_q.lock | bus_wdata[CTL_LOCK];
      if (ctl_q.lock) ctl_d.en = ctl_q.en | bus_wdata[CTL_EN];
      else begin
        ctl_d.en      = bus_wdata[CTL_EN];
        ctl_d.freerun = bus_wdata[CTL_MODE];
      end
    end
    en_rise = ctl_wr && !ctl_q.en && ctl_d.en;
    restart = (rld_wr && bus_wdata[RLD_RESTART]) || en_rise;
    run     = ctl_q.en && !expired;

    cfg_wr = bus_wr && (bus_addr == A_CFG) && bus_be[0] && !ctl_q.lock;
    cfg_d  = '{noboot: bus_wdata[CFG_NOBOOT], fast: bus_wdata[CFG_FAST],
               itype: bus_wdata[1:0]};

    isr_set = stage1_evt && (cfg_q.itype != ITYPE_NONE);
    isr_clr = bus_wr && (bus_addr == A_ISR) && bus_be[0] && bus_wdata[0];
    isr_d   = isr_set || (isr_q && !isr_clr);
    tmo_d   = timeout_evt || (tmo_q && !tmo_clr);

    pulse_d = pulse_q;
    pcnt_d  = pcnt_q;
    if (timeout_evt && !cfg_q.noboot) begin
      pulse_d = 1'b1;
      pcnt_d  = RC_W'(RST_CYC - 1);
    end else if (pcnt_q != '0) begin
      pcnt_d = pcnt_q - 1'b1;
    end else begin
      pulse_d = 1'b0;
    end
  end

  wdt_prescale #(.SLOW_SH(SLOW_SH), .FAST_SH(FAST_SH)) u_psc (
    .clk(clk), .rst_n(core_rst_n), .run(run), .clear(restart),
    .fast(cfg_q.fast), .tick(tick)
  );

  wdt_countdown #(.PW(PRE_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .restart(restart), .tick(tick),
    .freerun(ctl_q.freerun), .pre1(pre1_q), .pre2(pre2_q),
    .stage1_evt(stage1_evt), .timeout_evt(timeout_evt), .expired(expired)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pre1_q  <= PRE_INIT;
      pre2_q  <= PRE_INIT;
      ctl_q   <= '0;
      cfg_q   <= '0;
      isr_q   <= 1'b0;
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      if (pre1_ld) pre1_q <= pre1_d;
      if (pre2_ld) pre2_q <= pre2_d;
      if (ctl_wr)  ctl_q  <= ctl_d;
      if (cfg_wr)  cfg_q  <= cfg_d;
      isr_q   <= isr_d;
      pulse_q <= pulse_d;
      pcnt_q  <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) tmo_q <= 1'b0;
    else            tmo_q <= tmo_d;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_PRE1: bus_rdata = 32'(pre1_q);
      A_PRE2: bus_rdata = 32'(pre2_q);
      A_ISR:  bus_rdata[0] = isr_q;
      A_RLD:  bus_rdata[RLD_TMO] = tmo_q;
      A_CFG: begin
        bus_rdata[CFG_NOBOOT] = cfg_q.noboot;
        bus_rdata[CFG_FAST]   = cfg_q.fast;
        bus_rdata[1:0]        = cfg_q.itype;
      end
      A_CTL: begin
        bus_rdata[CTL_LOCK] = ctl_q.lock;
        bus_rdata[CTL_EN]   = ctl_q.en;
        bus_rdata[CTL_MODE] = ctl_q.freerun;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = isr_q;
  assign wdt_rst_o = pulse_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int RST_CYC = 8
) (
  input logic clk,
  input logic core_rst_n,
  input logic por_rst_n,
  input logic irq_o,
  input logic wdt_rst_o,
  input logic tmo_flag,
  input logic lock,
  input logic en,
  input logic accept,
  input logic isr_clr,
  input logic tmo_clr
);
  int hi_cnt;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)    hi_cnt <= 0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= 0;
  end

  // R2: an accepted guarded write closes the guard at once
  a_r2_single_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    accept |=> !accept);

  // R6: reset pulse starts only together with the timeout flag
  a_r6_pulse_flagged: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(wdt_rst_o) |-> tmo_flag);

  // R6: reset pulse never longer than RST_CYC cycles
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!core_rst_n)
    hi_cnt <= RST_CYC);

  // R8: lock is sticky
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!core_rst_n)
    lock |=> lock);

  // R8: locked enable cannot be cleared
  a_r8_enable_held: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lock && en) |=> en);

  // R9: flag only drops on an explicit clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_rst_n)
    (tmo_flag && !tmo_clr && core_rst_n) |=> tmo_flag);

  // R11: interrupt level holds until written with 1
  a_r11_irq_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (irq_o && !isr_clr) |=> irq_o);
endmodule

bind dual_stage_wdt wdt_checker #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .core_rst_n(core_rst_n), .por_rst_n(por_rst_n),
  .irq_o(irq_o), .wdt_rst_o(wdt_rst_o), .tmo_flag(tmo_q),
  .lock(ctl_q.lock), .en(ctl_q.en), .accept(prot_wr),
  .isr_clr(isr_clr), .tmo_clr(tmo_clr)
);

// File: tb/tb_dual_stage_wdt.sv
module tb_dual_stage_wdt;
  localparam int AW = 5;
  localparam int RC = 8;
  localparam int FAST = 32;
  localparam int SLOW = 32768;
  localparam logic [31:0] DEF = 32'd15360;
  localparam logic [7:0] PRE1 = 8'h00, PRE2 = 8'h04, ISR = 8'h08,
                         RLD = 8'h0C, CFG = 8'h10, CTL = 8'h14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          por_n, sys_rst_n, bus_wr, irq_o, wdt_rst_o;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata, bus_rdata;

  dual_stage_wdt #(.ADDR_W(AW), .RST_CYC(RC)) dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a[AW-1:0]; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[AW-1:0];
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(RLD, 32'h80, 4'h3);
    wr(RLD, 32'h86, 4'h3);
  endtask

  task automatic pwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    unlock();
    wr(a, d, be);
  endtask

  function automatic int ticks(input int p);
    return FAST * ((p == 0) ? 1 : p);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] w = old;
    for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
    return w & 32'h000F_FFFF;
  endfunction

  task automatic prepare();
    wr(CTL, 32'h0, 4'h1);
    wr(ISR, 32'h1, 4'h1);
    unlock();
    wr(RLD, 32'h300, 4'h3);
  endtask

  task automatic do_run(input int p1, input int p2, input logic [1:0] it, input bit noboot);
    logic [31:0] v;
    prepare();
    pwr(PRE1, p1, 4'hF);
    pwr(PRE2, p2, 4'hF);
    wr(CFG, {26'b0, noboot, 2'b0, 1'b1, it}, 4'h1);
    wr(CTL, 32'h2, 4'h1);
    idle(ticks(p1) - 1);
    check("R5 irq before stage-1 expiry", irq_o, 0);
    idle(1);
    check("R5 irq at stage-1 expiry", irq_o, (it != 2'b11));
    idle(ticks(p2) - 1);
    check("R6 no reset before stage-2 expiry", wdt_rst_o, 0);
    idle(1);
    check("R6 reset at stage-2 expiry", wdt_rst_o, !noboot);
    rd(RLD, v);
    check("R6 timeout flag set", v, 32'h200);
    if (!noboot) begin
      idle(RC - 1);
      check("R6 reset pulse last cycle", wdt_rst_o, 1);
      idle(1);
      check("R6 reset pulse ended", wdt_rst_o, 0);
    end
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v, m;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    por_n = 1'b0; sys_rst_n = 1'b1; bus_wr = 1'b0; bus_be = 4'h0;
    bus_addr = '0; bus_wdata = '0;
    idle(3); por_n = 1'b1; idle(4);

    // R1 reset state
    rd(PRE1, v); check("R1 stage-1 preload", v, DEF);
    rd(PRE2, v); check("R1 stage-2 preload", v, DEF);
    rd(ISR, v);  check("R1 status", v, 0);
    rd(RLD, v);  check("R1 flag", v, 0);
    rd(CFG, v);  check("R1 config", v, 0);
    rd(CTL, v);  check("R1 control", v, 0);
    check("R1 irq_o", irq_o, 0);
    check("R1 wdt_rst_o", wdt_rst_o, 0);

    // R2 / R3 guard
    wr(PRE1, 32'd5, 4'hF); rd(PRE1, v); check("R3 write without key", v, DEF);
    unlock(); wr(PRE1, 32'd5, 4'hF); rd(PRE1, v); check("R2 write after key", v, 5);
    wr(PRE1, 32'd9, 4'hF); rd(PRE1, v); check("R2 second write ignored", v, 5);
    wr(RLD, 32'h80, 4'h3); wr(CFG, 32'h0, 4'h1); wr(RLD, 32'h86, 4'h3);
    wr(PRE1, 32'd7, 4'hF); rd(PRE1, v); check("R3 other write cancels", v, 5);
    wr(RLD, 32'h80, 4'h3); wr(RLD, 32'h81, 4'h3); wr(RLD, 32'h86, 4'h3);
    wr(PRE1, 32'd7, 4'hF); rd(PRE1, v); check("R3 wrong value cancels", v, 5);
    unlock(); wr(CFG, 32'h0, 4'h1); wr(PRE2, 32'd11, 4'hF);
    rd(PRE2, v); check("R2 guard survives unguarded write", v, 11);

    // R4 byte lanes
    m = 32'd11;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      logic [3:0]  be;
      d  = $urandom;
      be = 4'($urandom % 16);
      m  = merge(m, d, be);
      pwr(PRE2, d, be);
      rd(PRE2, v); check("R4 byte-lane preload", v, m);
    end

    // R5 / R6 directed and random
    do_run(0, 0, 2'b01, 1'b0);
    do_run(4, 1, 2'b11, 1'b1);
    for (int i = 0; i < 6; i++)
      do_run(int'($urandom % 5), int'($urandom % 5), 2'($urandom % 4), 1'($urandom % 2));

    // R11 status clear
    do_run(1, 1, 2'b00, 1'b1);
    wr(ISR, 32'h0, 4'h1); check("R11 write 0 keeps irq", irq_o, 1);
    wr(ISR, 32'h1, 4'h1); check("R11 write 1 clears irq", irq_o, 0);

    // R7 restart and flag clear
    prepare();
    pwr(PRE1, 3, 4'hF); pwr(PRE2, 3, 4'hF);
    wr(CFG, 32'h04, 4'h1);
    wr(CTL, 32'h2, 4'h1);
    idle(50);
    unlock(); wr(RLD, 32'h100, 4'h2);
    idle(95); check("R7 restart postpones irq", irq_o, 0);
    idle(1);  check("R7 irq after restart", irq_o, 1);
    idle(96);
    rd(RLD, v); check("R7 flag set before clear", v, 32'h200);
    unlock(); wr(RLD, 32'h200, 4'h2);
    rd(RLD, v); check("R7 flag cleared by bit 9", v, 0);

    // R10 free-running
    prepare();
    pwr(PRE1, 2, 4'hF); pwr(PRE2, 1, 4'hF);
    wr(CFG, 32'h04, 4'h1);
    wr(CTL, 32'h6, 4'h1);
    idle(63); check("R10 first period low", irq_o, 0);
    idle(1);  check("R10 first period irq", irq_o, 1);
    wr(ISR, 32'h1, 4'h1);
    idle(61); check("R10 second period low", irq_o, 0);
    idle(1);  check("R10 second period irq", irq_o, 1);
    idle(200);
    rd(RLD, v); check("R10 no timeout", v, 0);
    check("R10 no reset", wdt_rst_o, 0);

    // R12 disabled
    prepare();
    pwr(PRE1, 1, 4'hF);
    wr(CFG, 32'h04, 4'h1);
    idle(300);
    check("R12 disabled irq", irq_o, 0);
    rd(RLD, v); check("R12 disabled flag", v, 0);

    // R13 slow rate
    prepare();
    pwr(PRE1, 1, 4'hF); pwr(PRE2, 1, 4'hF);
    wr(CFG, 32'h00, 4'h1);
    wr(CTL, 32'h2, 4'h1);
    idle(SLOW - 1); check("R13 slow tick not yet", irq_o, 0);
    idle(1);        check("R13 slow tick irq", irq_o, 1);
    idle(SLOW - 1); check("R13 slow stage 2 not yet", wdt_rst_o, 0);
    idle(1);        check("R13 slow stage 2 reset", wdt_rst_o, 1);
    idle(RC + 2);

    // R9 flag across resets
    sys_rst_n = 1'b0; idle(3); sys_rst_n = 1'b1; idle(4);
    rd(RLD, v);  check("R9 flag survives system reset", v, 32'h200);
    rd(PRE1, v); check("R9 system reset restores preload", v, DEF);
    por_n = 1'b0; idle(3); por_n = 1'b1; idle(4);
    rd(RLD, v);  check("R9 power-on reset clears flag", v, 0);

    // R8 lock
    wr(CTL, 32'h3, 4'h1);
    wr(CTL, 32'h0, 4'h1);
    rd(CTL, v); check("R8 enable cannot clear", v, 32'h3);
    wr(CTL, 32'h4, 4'h1);
    rd(CTL, v); check("R8 mode frozen", v, 32'h3);
    wr(CFG, 32'h24, 4'h1);
    rd(CFG, v); check("R8 config frozen", v, 0);

    finish_up();
  end
endmodule